// File: doc/BRIEF.md
# PCM Serial Port with Frame-Sync Mode Detection

This block moves 8-bit PCM words over a bit-clocked serial link. A transmit sequencer loads a parallel word at the start of each frame and shifts it out most significant bit first while it drives an output enable for an external tri-state pad. A receive sequencer shifts in 8 bits, again most significant bit first, and presents the word in parallel with a single-cycle valid strobe. The transmit and receive sides each have their own bit clock and frame sync. Every port signal is sampled on a fast system clock, and the sequencers act on the edges they detect there.

Two framing conventions are supported. A short sync is one bit period wide and announces the frame one period ahead. A long sync is three or more bit periods wide and marks the frame with its rising edge. The convention is not configured. It is measured from the width of each transmit sync pulse and used from the next frame onward. A power-down input aborts both sequencers and releases the pad.

Transmit states: `TX_IDLE` (waiting for a frame start), `TX_ARM` (frame seen, waiting for the bit clock to rise), `TX_SHIFT` (driving bits), `TX_TAIL` (last bit on the line, waiting for the bit clock to fall) and `TX_HOLD` (long frame whose sync is still high). Transitions: IDLE→ARM on a short trigger, or on a long trigger while the bit clock is low. IDLE→SHIFT on a long trigger while the bit clock is high. ARM→SHIFT on a rising bit clock. SHIFT→TAIL on the rising edge that puts the last bit out. TAIL→IDLE on a falling bit clock. TAIL→HOLD on a falling bit clock in long mode while the sync is still high. HOLD→IDLE when the sync goes low. Power-down takes any state to IDLE.

Receive states: `RX_IDLE`, `RX_SAMPLE` (capturing on falling edges) and `RX_DONE` (one-cycle presentation). Transitions: IDLE→SAMPLE on a trigger. SAMPLE→DONE on the eighth capture. DONE→IDLE unconditionally. Power-down takes any state to IDLE.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset the pad enable is low, the valid strobe is low and short-frame mode (frame_long = 0) is in force.
- R2: The transmit sync width is counted in falling transmit bit-clock edges seen while the sync is high. When the sync falls, a count of 1 selects short mode (frame_long = 0) and a count of 3 or more selects long mode (frame_long = 1). A count of 2 keeps the previous mode. A frame always runs in the mode in force when it starts.
- R3: Short transmit: once the sync is high at a falling bit-clock edge, the next rising edge raises the enable and drives bit 7. The following seven rising edges drive bits 6 down to 0. The falling edge after that drops the enable. The data line changes only on rising edges while the enable is high.
- R4: Long transmit start: on a sync rising edge, if the bit clock is already high, the enable rises at once with bit 7. Otherwise it rises with bit 7 on the next rising bit-clock edge. The next seven rising edges drive bits 6 down to 0.
- R5: Long transmit end: the enable drops at whichever comes later, the falling bit-clock edge after the eighth rising edge or the sync going low.
- R6: Short receive: once the receive sync is high at a falling receive bit-clock edge, the next eight falling edges capture the data input as bits 7 down to 0.
- R7: Long receive: after a receive sync rising edge, the next eight falling receive bit-clock edges capture bits 7 down to 0.
- R8: After the eighth capture, the word appears on rx_word with rx_valid high for exactly one system clock. No frame produces more than one strobe.
- R9: The transmit word is captured when the enable rises. Later changes on tx_word do not affect the bits sent in that frame.
- R10: Power-down drops the enable and aborts both sequencers on the next clock, so the aborted frame produces no strobe. It leaves the detected mode unchanged.
- R11: The receive side runs only on its own bit clock and sync. It completes frames while the transmit clock is stopped, and the pad stays released during those frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial signals |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_dn | input | 1 | Power-down: aborts both sequencers and releases the pad |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_fsync | input | 1 | Transmit frame sync; its width sets the mode |
| tx_word | input | WORD_W | Parallel word to send |
| tx_sdo | output | 1 | Serial data out |
| tx_oe | output | 1 | Enable for the external tri-state driver |
| rx_bclk | input | 1 | Receive bit clock |
| rx_fsync | input | 1 | Receive frame sync |
| rx_sdi | input | 1 | Serial data in |
| rx_word | output | WORD_W | Last received word |
| rx_valid | output | 1 | One-cycle strobe when rx_word is updated |
| frame_long | output | 1 | Detected framing: 0 short, 1 long |

## Verification
The bench walks every transmit and receive word in both modes. It also covers the mode switches, where a frame must still run in the old mode. Starting a switched frame in its own new mode would move the enable and every data bit by one period. Sync widths of 1, 2, 3, 4, 8 and 10 periods are exercised. A sequencer that ignored the "later of" rule would drop the enable while a long sync was still high. A width of 2 that changed the mode would break the following frame. Power-down in the middle of a frame, a tx_word change after the frame has started, and receive frames with the transmit clock stopped are all checked. A design that mishandled any of these would leak bits, emit a stale strobe or drive the pad.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_ARM,
        TX_SHIFT,
        TX_TAIL,
        TX_HOLD
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_SAMPLE,
        RX_DONE
    } rx_state_e;

    typedef enum logic {
        FRAME_SHORT = 1'b0,
        FRAME_LONG  = 1'b1
    } frame_mode_e;

endpackage

// File: rtl/pcm_edge_reg.sv
module pcm_edge_reg #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] din,
    output logic [LANES-1:0] prev
);

    // One delay stage per lane; edges are formed by the consumer.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev[g] <= 1'b0;
            end else begin
                prev[g] <= din[g];
            end
        end
    end

endmodule

// File: rtl/pcm_mode_det.sv
module pcm_mode_det
    import pcm_port_pkg::*;
#(
    parameter int LONG_MIN = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fs_lvl,
    input  logic        fs_rise,
    input  logic        fs_fall,
    input  logic        bclk_fall,
    output frame_mode_e mode
);

    localparam int            CW   = $clog2(LONG_MIN + 1);
    localparam logic [CW-1:0] LMAX = CW'(LONG_MIN);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] width_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_q <= '0;
            mode    <= FRAME_SHORT;
        end else begin
            // count bit periods covered by the sync, saturating at LONG_MIN
            if (fs_rise) begin
                width_q <= bclk_fall ? ONE : '0;
            end else if (fs_lvl && bclk_fall && (width_q != LMAX)) begin
                width_q <= width_q + ONE;
            end
            // decision at the end of the pulse; two periods keeps the mode
            if (fs_fall) begin
                if (width_q == ONE) begin
                    mode <= FRAME_SHORT;
                end else if (width_q >= LMAX) begin
                    mode <= FRAME_LONG;
                end
            end
        end
    end

endmodule

// File: rtl/pcm_tx_seq.sv
module pcm_tx_seq
    import pcm_port_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_dn,
    input  frame_mode_e       mode,
    input  logic              bclk_lvl,
    input  logic              bclk_rise,
    input  logic              bclk_fall,
    input  logic              fs_lvl,
    input  logic              fs_rise,
    input  logic [WORD_W-1:0] word_in,
    output logic              sdo,
    output logic              oe
);

    localparam int               CNT_W      = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_SHIFT = CNT_W'(WORD_W - 2);

    tx_state_e          st_q, st_d;
    frame_mode_e        fm_q, fm_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [WORD_W-1:0]  sh_q, sh_d;

    // next-state logic
    always_comb begin
        st_d  = st_q;
        fm_d  = fm_q;
        cnt_d = cnt_q;
        sh_d  = sh_q;
        unique case (st_q)
            TX_IDLE: begin
                fm_d = mode;
                if (mode == FRAME_SHORT) begin
                    if (bclk_fall && fs_lvl) begin
                        st_d = TX_ARM;
                    end
                end else if (fs_rise) begin
                    if (bclk_lvl) begin
                        st_d  = TX_SHIFT;
                        sh_d  = word_in;
                        cnt_d = '0;
                    end else begin
                        st_d = TX_ARM;
                    end
                end
            end
            TX_ARM: begin
                if (bclk_rise) begin
                    st_d  = TX_SHIFT;
                    sh_d  = word_in;
                    cnt_d = '0;
                end
            end
            TX_SHIFT: begin
                if (bclk_rise) begin
                    sh_d  = {sh_q[WORD_W-2:0], 1'b0};
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == LAST_SHIFT) begin
                        st_d = TX_TAIL;
                    end
                end
            end
            TX_TAIL: begin
                if (bclk_fall) begin
                    st_d = ((fm_q == FRAME_LONG) && fs_lvl) ? TX_HOLD : TX_IDLE;
                end
            end
            TX_HOLD: begin
                if (!fs_lvl) begin
                    st_d = TX_IDLE;
                end
            end
            default: st_d = TX_IDLE;
        endcase
        if (pwr_dn) begin
            st_d = TX_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= TX_IDLE;
            fm_q  <= FRAME_SHORT;
            cnt_q <= '0;
            sh_q  <= '0;
        end else begin
            st_q  <= st_d;
            fm_q  <= fm_d;
            cnt_q <= cnt_d;
            sh_q  <= sh_d;
        end
    end

    // outputs
    always_comb begin
        oe  = (st_q == TX_SHIFT) || (st_q == TX_TAIL) || (st_q == TX_HOLD);
        sdo = oe ? sh_q[WORD_W-1] : 1'b0;
    end

endmodule

// File: rtl/pcm_rx_seq.sv
module pcm_rx_seq
    import pcm_port_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_dn,
    input  frame_mode_e       mode,
    input  logic              bclk_fall,
    input  logic              fs_lvl,
    input  logic              fs_rise,
    input  logic              sdi,
    output logic [WORD_W-1:0] word,
    output logic              valid
);

    localparam int               CNT_W    = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    rx_state_e          st_q, st_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [WORD_W-1:0]  sh_q, sh_d;
    logic [WORD_W-1:0]  word_q, word_d;
    logic               trig;

    always_comb begin
        trig = ((mode == FRAME_SHORT) && bclk_fall && fs_lvl) ||
               ((mode == FRAME_LONG) && fs_rise);
    end

    // next-state logic
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        sh_d   = sh_q;
        word_d = word_q;
        unique case (st_q)
            RX_IDLE: begin
                if (trig) begin
                    st_d  = RX_SAMPLE;
                    cnt_d = '0;
                end
            end
            RX_SAMPLE: begin
                if (bclk_fall) begin
                    sh_d  = {sh_q[WORD_W-2:0], sdi};
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == LAST_BIT) begin
                        st_d   = RX_DONE;
                        word_d = {sh_q[WORD_W-2:0], sdi};
                    end
                end
            end
            RX_DONE: st_d = RX_IDLE;
            default: st_d = RX_IDLE;
        endcase
        if (pwr_dn) begin
            st_d = RX_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= RX_IDLE;
            cnt_q  <= '0;
            sh_q   <= '0;
            word_q <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            sh_q   <= sh_d;
            word_q <= word_d;
        end
    end

    // outputs
    always_comb begin
        valid = (st_q == RX_DONE);
        word  = word_q;
    end

endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
    import pcm_port_pkg::*;
#(
    parameter int WORD_W   = 8,
    parameter int LONG_MIN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_dn,
    input  logic              tx_bclk,
    input  logic              tx_fsync,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_sdo,
    output logic              tx_oe,
    input  logic              rx_bclk,
    input  logic              rx_fsync,
    input  logic              rx_sdi,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              frame_long
);

    localparam int LANES = 4;
    localparam int L_TXB = 0;
    localparam int L_TXF = 1;
    localparam int L_RXB = 2;
    localparam int L_RXF = 3;

    logic [LANES-1:0] lane_now, lane_prev;
    logic tx_b_rise, tx_b_fall, tx_f_rise, tx_f_fall;
    logic rx_b_fall, rx_f_rise;
    frame_mode_e mode;

    assign lane_now = {rx_fsync, rx_bclk, tx_fsync, tx_bclk};

    pcm_edge_reg #(.LANES(LANES)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (lane_now),
        .prev (lane_prev)
    );

    assign tx_b_rise = lane_now[L_TXB] & ~lane_prev[L_TXB];
    assign tx_b_fall = ~lane_now[L_TXB] & lane_prev[L_TXB];
    assign tx_f_rise = lane_now[L_TXF] & ~lane_prev[L_TXF];
    assign tx_f_fall = ~lane_now[L_TXF] & lane_prev[L_TXF];
    assign rx_b_fall = ~lane_now[L_RXB] & lane_prev[L_RXB];
    assign rx_f_rise = lane_now[L_RXF] & ~lane_prev[L_RXF];

    pcm_mode_det #(.LONG_MIN(LONG_MIN)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .fs_lvl   (tx_fsync),
        .fs_rise  (tx_f_rise),
        .fs_fall  (tx_f_fall),
        .bclk_fall(tx_b_fall),
        .mode     (mode)
    );

    pcm_tx_seq #(.WORD_W(WORD_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_dn   (pwr_dn),
        .mode     (mode),
        .bclk_lvl (tx_bclk),
        .bclk_rise(tx_b_rise),
        .bclk_fall(tx_b_fall),
        .fs_lvl   (tx_fsync),
        .fs_rise  (tx_f_rise),
        .word_in  (tx_word),
        .sdo      (tx_sdo),
        .oe       (tx_oe)
    );

    pcm_rx_seq #(.WORD_W(WORD_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_dn   (pwr_dn),
        .mode     (mode),
        .bclk_fall(rx_b_fall),
        .fs_lvl   (rx_fsync),
        .fs_rise  (rx_f_rise),
        .sdi      (rx_sdi),
        .word     (rx_word),
        .valid    (rx_valid)
    );

    assign frame_long = (mode == FRAME_LONG);

endmodule

// File: rtl/pcm_serial_port_chk.sv
module pcm_serial_port_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_dn,
    input logic tx_bclk,
    input logic tx_fsync,
    input logic tx_sdo,
    input logic tx_oe,
    input logic rx_bclk,
    input logic rx_valid,
    input logic frame_long
);

    AST_PD_OE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> !tx_oe);  // R10

    AST_PD_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> !rx_valid);  // R10

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);  // R8

    AST_VALID_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> (!$past(rx_bclk) && $past(rx_bclk, 2)));  // R8

    AST_OE_RISE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_oe) |-> (($past(tx_bclk) && !$past(tx_bclk, 2)) ||
                          ($past(tx_fsync) && !$past(tx_fsync, 2))));  // R4

    AST_OE_FALL_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_oe) |-> ((!$past(tx_bclk) && $past(tx_bclk, 2)) ||
                          (!$past(tx_fsync) && $past(tx_fsync, 2)) ||
                          $past(pwr_dn)));  // R5

    AST_SDO_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_oe && $past(tx_oe) && !($past(tx_bclk) && !$past(tx_bclk, 2)))
            |-> $stable(tx_sdo));  // R3

    AST_MODE_ON_FS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_long) |-> (!$past(tx_fsync) && $past(tx_fsync, 2)));  // R2

endmodule

bind pcm_serial_port pcm_serial_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_dn    (pwr_dn),
    .tx_bclk   (tx_bclk),
    .tx_fsync  (tx_fsync),
    .tx_sdo    (tx_sdo),
    .tx_oe     (tx_oe),
    .rx_bclk   (rx_bclk),
    .rx_valid  (rx_valid),
    .frame_long(frame_long)
);

// File: tb/pcm_serial_port_tb.sv
module pcm_serial_port_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_dn = 1'b0;
    logic       tx_bclk = 1'b0;
    logic       tx_fsync = 1'b0;
    logic [7:0] tx_word = 8'h00;
    logic       tx_sdo;
    logic       tx_oe;
    logic       rx_bclk = 1'b0;
    logic       rx_fsync = 1'b0;
    logic       rx_sdi = 1'b0;
    logic [7:0] rx_word;
    logic       rx_valid;
    logic       frame_long;

    int n_chk = 0;
    int n_bad = 0;
    int vcount = 0;
    int vper = -1;
    int vwide = 0;
    int cur_p = 0;
    logic [7:0] vword = 8'h00;
    logic prev_v = 1'b0;
    bit exp_long = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pcm_serial_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_dn    (pwr_dn),
        .tx_bclk   (tx_bclk),
        .tx_fsync  (tx_fsync),
        .tx_word   (tx_word),
        .tx_sdo    (tx_sdo),
        .tx_oe     (tx_oe),
        .rx_bclk   (rx_bclk),
        .rx_fsync  (rx_fsync),
        .rx_sdi    (rx_sdi),
        .rx_word   (rx_word),
        .rx_valid  (rx_valid),
        .frame_long(frame_long)
    );

    // strobe monitor: count pulses, remember word, period and over-long pulses
    always @(negedge clk) begin
        if (rx_valid) begin
            vcount = vcount + 1;
            vper   = cur_p;
            vword  = rx_word;
            if (prev_v) vwide = vwide + 1;
        end
        prev_v = rx_valid;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // one frame of 12 bit periods, 8 system clocks each; sync is w periods wide
    task automatic run_frame(input logic [7:0] tw, input logic [7:0] rw,
                             input int w, input bit txon, input int pd);
        bit   lng;
        int   off;
        int   v0;
        int   w0;
        bit   cut;
        bit   eoh;
        bit   eol;
        bit   expv;
        string tg;
        lng = exp_long;
        off = lng ? 0 : 1;
        v0  = vcount;
        w0  = vwide;
        tx_word = tw;
        for (int p = 0; p < 12; p++) begin
            cut = (pd >= 0) && (p >= pd);
            @(negedge clk);
            cur_p    = p;
            tx_bclk  = txon;
            rx_bclk  = 1'b1;
            tx_fsync = txon && (p < w);
            rx_fsync = (p < w);
            pwr_dn   = (pd >= 0) && (p == pd);
            if (p == off + 1) tx_word = ~tw;  // R9: late change must not reach the line
            rx_sdi = (p >= off && p <= off + 7) ? rw[7 - (p - off)] : p[0];
            repeat (3) @(negedge clk);
            eoh = txon && !cut && ((p >= off && p <= off + 7) || (lng && p < w));
            tg = (pd >= 0) ? "R10 enable" : (!txon ? "R11 enable" : (lng ? "R4 enable" : "R3 enable"));
            chk(tx_oe == eoh, tg, tx_oe, eoh);
            if (eoh && p >= off && p <= off + 7) begin
                chk(tx_sdo == tw[7 - (p - off)], lng ? "R4/R9 data" : "R3/R9 data",
                    tx_sdo, tw[7 - (p - off)]);
            end
            @(negedge clk);
            tx_bclk = 1'b0;
            rx_bclk = 1'b0;
            repeat (3) @(negedge clk);
            eol = txon && !cut && ((p >= off && p <= off + 6) || (lng && p < w));
            tg = (pd >= 0) ? "R10 enable" : (!txon ? "R11 enable" : (lng ? "R5 enable" : "R3 enable"));
            chk(tx_oe == eol, tg, tx_oe, eol);
        end
        pwr_dn = 1'b0;
        expv = !((pd >= 0) && (pd <= off + 7));
        chk((vcount - v0) == int'(expv), (pd >= 0) ? "R10 strobe count" : "R8 strobe count",
            vcount - v0, int'(expv));
        if (expv) begin
            chk(vword == rw, lng ? "R7 word" : "R6 word", vword, rw);
            chk(vper == off + 7, "R8 strobe period", vper, off + 7);
        end
        chk(vwide == w0, "R8 strobe width", vwide, w0);
        if (txon) begin
            if (w == 1) exp_long = 1'b0;
            else if (w >= 3) exp_long = 1'b1;
        end
        chk(frame_long == exp_long, (pd >= 0) ? "R2/R10 mode" : "R2 mode", frame_long, exp_long);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_oe == 1'b0, "R1 enable", tx_oe, 0);
        chk(rx_valid == 1'b0, "R1 strobe", rx_valid, 0);
        chk(frame_long == 1'b0, "R1 mode", frame_long, 0);

        // short mode, every word (R3, R6)
        for (int i = 0; i < 256; i++) run_frame(8'(i), 8'(i) ^ 8'h5A, 1, 1'b1, -1);
        run_frame(8'hC3, 8'h3C, 2, 1'b1, -1);   // R2: width 2 keeps short
        run_frame(8'h81, 8'h7E, 3, 1'b1, -1);   // R2: runs short, switches to long
        // long mode, every word (R4, R5, R7)
        for (int i = 0; i < 256; i++) run_frame(8'(255 - i), 8'(i) ^ 8'hA5, 3, 1'b1, -1);
        run_frame(8'h96, 8'h69, 10, 1'b1, -1);  // R5: sync outlasts the word
        run_frame(8'h5B, 8'hB5, 8, 1'b1, -1);   // R5: sync ends just after
        run_frame(8'hE7, 8'h18, 4, 1'b1, -1);
        run_frame(8'h0F, 8'hF0, 2, 1'b1, -1);   // R2: width 2 keeps long
        run_frame(8'hAA, 8'h55, 2, 1'b1, 3);    // R10 in long mode
        run_frame(8'h33, 8'hCC, 3, 1'b1, -1);
        run_frame(8'h00, 8'hD2, 3, 1'b0, -1);   // R11: receive alone, long
        run_frame(8'h71, 8'h17, 1, 1'b1, -1);   // runs long, switches to short
        run_frame(8'h00, 8'h2D, 1, 1'b0, -1);   // R11: receive alone, short
        run_frame(8'h42, 8'h24, 3, 1'b1, -1);   // runs short, switches to long
        run_frame(8'h99, 8'h66, 1, 1'b1, -1);   // runs long, back to short
        run_frame(8'hF1, 8'h1F, 2, 1'b1, 5);    // R10 in short mode
        run_frame(8'h5C, 8'hC5, 1, 1'b1, -1);

        done = 1'b1;
        report();
        $finish;
    end

endmodule